// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block takes two single-precision IEEE-754 operands and reports how they relate as a one-hot code. The compare is quiet: it never traps, and it treats a quiet NaN as an ordinary unordered result. The result word also has one indicator bit per operand that marks a nonzero denormal input. Denormals are compared at their true values and are never flushed to zero.

Each compare also updates the status flags. An invalid indication is raised only when an input is a signaling NaN. The summary exception flag is rewritten on every compare: it is set when the operation raised an exception and cleared when it did not. A sticky invalid flag gathers every invalid event until reset.

Operands enter through a valid/ready stream, and results leave through a valid/ready stream. An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and shows up the next cycle with `out_valid` high. It stays stable until a clock edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in that cycle, so back-pressure on the output stalls the input.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `sticky_invalid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. A pair accepted at a clock edge produces `out_valid` = 1 after that edge. While `out_ready` is 0, the output holds its values and no new pair is accepted.
- R3: For ordered operands, exactly one of result bits 0 (A less than B), 1 (equal) and 2 (A greater than B) is set. This holds for any combination of signs, including infinities (exponent 0xFF with a zero fraction).
- R4: Positive zero (0x00000000) and negative zero (0x80000000) compare as equal (result bit 1).
- R5: A nonzero denormal (exponent 0, fraction nonzero) is compared at its true value. It is not flushed: +denormal > +0, -denormal < +0, and two denormals are ordered by magnitude.
- R6: Result bit 4 is set when A is a nonzero denormal, and bit 5 is set when B is a nonzero denormal. A zero sets neither bit. Both bits are reported even when the pair is unordered.
- R7: A NaN is exponent 0xFF with a nonzero fraction. It is quiet when fraction bit 22 is 1. When an operand is a quiet NaN and neither operand is a signaling NaN, only bit 3 (unordered) of bits 3:0 is set, `out_invalid` is 0 and `out_summary` is 0.
- R8: A signaling NaN (fraction bit 22 = 0, fraction nonzero) on either input gives the unordered code (bit 3), sets `out_invalid` to 1 and sets `out_summary` to 1.
- R9: `sticky_invalid` becomes 1 with the first result that has `out_invalid` set and stays 1 until reset. `out_summary` returns to 0 on the next compare that raises no exception.
- R10: Result bits 31 down to 6 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is valid |
| in_ready | output | 1 | Unit can accept an operand pair |
| in_a | input | 32 | Operand A, single precision |
| in_b | input | 32 | Operand B, single precision |
| out_valid | output | 1 | Result and flag updates are valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Relation code (bits 3:0) and denormal indicators (bits 5:4) |
| out_summary | output | 1 | Summary exception flag for this compare |
| out_invalid | output | 1 | Invalid raised by this compare |
| sticky_invalid | output | 1 | Sticky invalid flag, cleared only by reset |

## Verification
Positive, negative and mixed-sign normal pairs, including infinities, separate the three ordered codes and check that the sign handling reverses the magnitude order for negatives. Signed zeros and small denormal pairs show whether zeros collapse to equal while denormals keep their true order, which also exercises the denormal indicator bits. Quiet and signaling NaNs, on each side and next to a denormal, show whether the invalid and summary flags depend on the NaN kind rather than on NaN presence. A stalled output with a second pair offered checks that back-pressure holds the result and that the offered pair is not taken.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int RES_W = 32;

  // bit positions of the result word
  localparam int BIT_LT  = 0;
  localparam int BIT_EQ  = 1;
  localparam int BIT_GT  = 2;
  localparam int BIT_UN  = 3;
  localparam int BIT_DNA = 4;
  localparam int BIT_DNB = 5;

  typedef struct packed {
    logic sign;
    logic zero;
    logic denorm;
    logic nan;
    logic snan;
  } fp_kind_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]   op,
  output fpcmp_pkg::fp_kind_t    kind,
  output logic [EXP_W+MAN_W-1:0] mag
);
  localparam int MSB = EXP_W + MAN_W;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  logic exp_max, exp_min, frac_nz;

  always_comb begin
    expo    = op[MSB-1 -: EXP_W];
    frac    = op[MAN_W-1:0];
    exp_max = &expo;
    exp_min = ~|expo;
    frac_nz = |frac;
    mag     = op[MSB-1:0];
    kind.sign   = op[MSB];
    kind.zero   = exp_min & ~frac_nz;
    kind.denorm = exp_min & frac_nz;
    kind.nan    = exp_max & frac_nz;
    kind.snan   = exp_max & frac_nz & ~frac[MAN_W-1];
  end
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate #(
  parameter int MAG_W = 31
) (
  input  fpcmp_pkg::fp_kind_t kind_a,
  input  fpcmp_pkg::fp_kind_t kind_b,
  input  logic [MAG_W-1:0]    mag_a,
  input  logic [MAG_W-1:0]    mag_b,
  output logic                rel_lt,
  output logic                rel_eq,
  output logic                rel_gt,
  output logic                rel_un
);
  logic mag_less, mag_same;

  always_comb begin
    mag_less = mag_a < mag_b;
    mag_same = mag_a == mag_b;
    rel_lt = 1'b0;
    rel_eq = 1'b0;
    rel_gt = 1'b0;
    rel_un = 1'b0;
    if (kind_a.nan || kind_b.nan) begin
      rel_un = 1'b1;
    end else if (kind_a.zero && kind_b.zero) begin
      rel_eq = 1'b1;
    end else if (kind_a.sign != kind_b.sign) begin
      rel_lt = kind_a.sign;
      rel_gt = ~kind_a.sign;
    end else if (mag_same) begin
      rel_eq = 1'b1;
    end else if (kind_a.sign) begin
      rel_lt = ~mag_less;
      rel_gt = mag_less;
    end else begin
      rel_lt = mag_less;
      rel_gt = ~mag_less;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_a,
  input  logic [FP_W-1:0]  in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_result,
  output logic             out_summary,
  output logic             out_invalid,
  output logic             sticky_invalid
);
  localparam int MAG_W = FP_W - 1;

  logic [FP_W-1:0]  ops  [2];
  fp_kind_t         kind [2];
  logic [MAG_W-1:0] mag  [2];

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[g]),
      .kind(kind[g]),
      .mag (mag[g])
    );
  end

  logic lt, eq, gt, un;
  fpcmp_relate #(.MAG_W(MAG_W)) u_rel (
    .kind_a(kind[0]),
    .kind_b(kind[1]),
    .mag_a (mag[0]),
    .mag_b (mag[1]),
    .rel_lt(lt),
    .rel_eq(eq),
    .rel_gt(gt),
    .rel_un(un)
  );

  logic [RES_W-1:0] word_nxt;
  logic             inv_nxt;
  logic             accept;

  always_comb begin
    word_nxt          = '0;
    word_nxt[BIT_LT]  = lt;
    word_nxt[BIT_EQ]  = eq;
    word_nxt[BIT_GT]  = gt;
    word_nxt[BIT_UN]  = un;
    word_nxt[BIT_DNA] = kind[0].denorm;
    word_nxt[BIT_DNB] = kind[1].denorm;
    // a quiet compare raises only invalid, and only for signaling NaNs
    inv_nxt = kind[0].snan | kind[1].snan;
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_result     <= '0;
      out_summary    <= 1'b0;
      out_invalid    <= 1'b0;
      sticky_invalid <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= word_nxt;
      out_invalid <= inv_nxt;
      out_summary <= inv_nxt;
      if (inv_nxt) sticky_invalid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result,
  input logic        out_summary,
  input logic        out_invalid,
  input logic        sticky_invalid
);
  assert_ready_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  assert_accept_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_result[3:0]) == 1));

  assert_invalid_unordered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_result[3] && out_summary));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_invalid |=> sticky_invalid);

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[31:6] == 26'd0));
endmodule

bind fpcmp_unit fpcmp_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_result    (out_result),
  .out_summary   (out_summary),
  .out_invalid   (out_invalid),
  .sticky_invalid(sticky_invalid)
);

// File: tb/fpcmp_unit_tb.sv
module fpcmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_summary;
  logic        out_invalid;
  logic        sticky_invalid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fpcmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_summary(out_summary),
    .out_invalid(out_invalid), .sticky_invalid(sticky_invalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one compare with the output drained; checks result and flags
  task automatic cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp_word, input logic exp_inv);
    @(negedge clk);
    check({req, " in_ready"}, {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, out_result, exp_word);
    check({req, " invalid"}, {31'd0, out_invalid}, {31'd0, exp_inv});
    check({req, " summary"}, {31'd0, out_summary}, {31'd0, exp_inv});
  endtask

  task automatic t_reset;
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 sticky", {31'd0, sticky_invalid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_ordered;
    cmp("R3 pos lt", 32'h3F800000, 32'h40000000, 32'h1, 1'b0);
    cmp("R3 pos gt", 32'h40000000, 32'h3F800000, 32'h4, 1'b0);
    cmp("R3 eq",     32'h3F800000, 32'h3F800000, 32'h2, 1'b0);
    cmp("R3 neg lt", 32'hC0000000, 32'hBF800000, 32'h1, 1'b0);
    cmp("R3 neg gt", 32'hBF800000, 32'hC0000000, 32'h4, 1'b0);
    cmp("R3 mixed",  32'hBF800000, 32'h3F800000, 32'h1, 1'b0);
    cmp("R3 inf",    32'h7F800000, 32'h3F800000, 32'h4, 1'b0);
    cmp("R10 upper", 32'hFF800000, 32'h7F800000, 32'h1, 1'b0);
  endtask

  task automatic t_zero;
    cmp("R4 +0 -0", 32'h00000000, 32'h80000000, 32'h2, 1'b0);
    cmp("R4 -0 +0", 32'h80000000, 32'h00000000, 32'h2, 1'b0);
  endtask

  task automatic t_denorm;
    cmp("R5 R6 dnA gt 0",   32'h00000001, 32'h00000000, 32'h14, 1'b0);
    cmp("R5 R6 0 lt dnB",   32'h00000000, 32'h00000002, 32'h21, 1'b0);
    cmp("R5 R6 both dn",    32'h00000001, 32'h00000002, 32'h31, 1'b0);
    cmp("R5 R6 neg dn",     32'h80000001, 32'h00000000, 32'h11, 1'b0);
  endtask

  task automatic t_nan;
    cmp("R7 qnan A", 32'h7FC00000, 32'h3F800000, 32'h8, 1'b0);
    check("R7 sticky", {31'd0, sticky_invalid}, 32'd0);
    cmp("R7 qnan B", 32'h3F800000, 32'hFFC00001, 32'h8, 1'b0);
    cmp("R8 snan A", 32'h7F800001, 32'h3F800000, 32'h8, 1'b1);
    check("R9 sticky set", {31'd0, sticky_invalid}, 32'd1);
    cmp("R8 R6 snan B dnA", 32'h00000001, 32'h7FA00000, 32'h18, 1'b1);
    cmp("R9 clean after", 32'h3F800000, 32'h40000000, 32'h1, 1'b0);
    check("R9 sticky kept", {31'd0, sticky_invalid}, 32'd1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 32'h40000000; in_b = 32'h3F800000;
    @(negedge clk);
    check("R2 stall valid", {31'd0, out_valid}, 32'd1);
    check("R2 stall ready", {31'd0, in_ready}, 32'd0);
    in_a = 32'h3F800000; in_b = 32'h40000000;
    @(negedge clk);
    check("R2 held", out_result, 32'h4);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R2 drained", {31'd0, out_valid}, 32'd0);
    check("R2 ready again", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ordered();
    t_zero();
    t_denorm();
    t_nan();
    t_backpressure();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule